// File: doc/BRIEF.md
# Freezable divide-by-2/4/8 clock generator

This block takes one input clock and produces three divided outputs at one half, one quarter and one eighth of the input rate. The outputs come from one registered down-counter that advances on rising input edges. Because the counter counts down from zero, all three outputs go high on the same edge, and every rising edge of a slower output coincides with rising edges of the faster ones.

A freeze input is sampled on the falling input edge. While the sampled value is high, the counter holds its state. When freeze is released, the counter carries on from the held value, so the phase relationship between the outputs is unchanged. An asynchronous master reset clears the counter at once. Its release passes through two falling-edge stages, so the first output change comes on the second rising edge after release if the clock was high at release, and on the third rising edge if the clock was low.

Top module: `clk_div_freeze`

## Requirements
- R1: While the counter is running, the divide-by-2 output changes state on every rising edge of the clock.
- R2: While running, the divide-by-4 output changes state every second running edge and the divide-by-8 output every fourth, giving 16, 8 and 4 rising edges on the three outputs over 32 running edges.
- R3: The outputs, read as the value {div8, div4, div2}, count down modulo 8 starting from 0. All three go high together on the first running edge. On any edge where div8 rises, div4 and div2 rise as well.
- R4: A freeze level of 1 that is sampled on a falling edge stops the counter. The outputs then hold their value on every later rising edge until a falling edge samples freeze as 0.
- R5: After a falling edge samples freeze as 0, the next rising edge moves the outputs from the held value to that value minus 1, modulo 8.
- R6: Asserting rst high drives all three outputs low immediately, without waiting for a clock edge, and holds them low for as long as rst stays high.
- R7: If rst is released while clk is high, the outputs stay low on the first rising edge after the release and go high on the second.
- R8: If rst is released while clk is low, the outputs stay low on the first and second rising edges after the release and go high on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Asynchronous master reset, active high |
| freeze | input | 1 | Freeze request, sampled on the falling clock edge |
| div2 | output | 1 | Clock divided by 2 |
| div4 | output | 1 | Clock divided by 4 |
| div8 | output | 1 | Clock divided by 8 |

## Verification
The assertions take for granted that freeze and the release of rst change only away from both clock edges. Under that condition the falling-edge qualifier is always settled at each rising edge, and the hold and toggle properties can be stated on a single edge. The bench drives every input change a few time units after an edge, either while clk is high or while it is low. Both release phases are used on purpose, to reach the two latency cases.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

  // Next value of a w-bit down-counter (wraps 0 -> all ones).
  function automatic logic [31:0] next_down(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (v + mask) & mask;
  endfunction

  // True when a counter bit flips on the next decrement: all lower bits are zero.
  function automatic logic bit_flips(input logic [31:0] v, input int unsigned idx);
    logic [31:0] low;
    low = (32'd1 << idx) - 32'd1;
    return (v & low) == 32'd0;
  endfunction

endpackage

// File: rtl/release_sync.sv
module release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(negedge clk or posedge rst) begin
        if (rst) sh <= '0;
        else     sh <= 1'b1;
      end
    end else begin : g_many
      always_ff @(negedge clk or posedge rst) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign ready = sh[STAGES-1];

  // R7 / R8: once the release has propagated it stays until the next reset
  a_r7_ready_sticks: assert property (@(negedge clk) disable iff (rst)
    ready |=> ready);

endmodule

// File: rtl/freeze_sample.sv
module freeze_sample (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  output logic frz_q
);
  always_ff @(negedge clk or posedge rst) begin
    if (rst) frz_q <= 1'b0;
    else     frz_q <= freeze;
  end
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt
);
  import clk_div_pkg::*;

  logic [31:0] cnt_ext;
  logic [31:0] nxt_ext;

  assign cnt_ext = 32'(cnt);
  assign nxt_ext = next_down(cnt_ext, CNT_W);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= nxt_ext[CNT_W-1:0];
  end

  // R1: LSB flips on every running edge
  a_r1_lsb_toggles: assert property (@(posedge clk) disable iff (rst)
    adv |=> cnt[0] != $past(cnt[0]));

  // R2: bit 1 flips exactly when bit 0 borrows
  a_r2_bit1_borrow: assert property (@(posedge clk) disable iff (rst)
    (adv && !cnt[0]) |=> cnt[1] != $past(cnt[1]));

  a_r2_bit1_keeps: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt[0]) |=> cnt[1] == $past(cnt[1]));

  // R4: no advance means no change
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));

endmodule

// File: rtl/clk_div_freeze.sv
module clk_div_freeze #(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  output logic div2,
  output logic div4,
  output logic div8
);
  logic             rel_ready;
  logic             frz_q;
  logic             run;
  logic [CNT_W-1:0] cnt;

  release_sync #(.STAGES(SYNC_STAGES)) u_rel (
    .clk   (clk),
    .rst   (rst),
    .ready (rel_ready)
  );

  freeze_sample u_frz (
    .clk    (clk),
    .rst    (rst),
    .freeze (freeze),
    .frz_q  (frz_q)
  );

  assign run = rel_ready & ~frz_q;

  down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .adv (run),
    .cnt (cnt)
  );

  assign div2 = cnt[0];
  assign div4 = cnt[1];
  assign div8 = cnt[2];

  // R3: rising edges of slower outputs line up with faster ones
  a_r3_div8_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(div8) |-> ($rose(div4) && $rose(div2)));

  a_r3_div4_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(div4) |-> $rose(div2));

  // R5: a running edge after a frozen one advances the held value
  a_r5_resume: assert property (@(posedge clk) disable iff (rst)
    (run && $past(!run)) |=> div2 != $past(div2));

  // R6: outputs low whenever reset is held
  always @(negedge clk) begin
    if (rst) begin
      a_r6_reset_low: assert ({div8, div4, div2} == 3'b000);
    end
  end

endmodule

// File: tb/sim_clk_div_freeze.sv
module sim_clk_div_freeze;
  localparam int  PERIOD = 10;
  localparam int  WD_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic freeze = 1'b0;
  logic div2, div4, div8;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int m_rel = 0;
  int m_frz = 0;
  int m_val = 0;

  clk_div_freeze u0 (
    .clk(clk), .rst(rst), .freeze(freeze),
    .div2(div2), .div4(div4), .div8(div8)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int outv();
    return {29'd0, div8, div4, div2};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: release count and freeze sample on falling edges
  always @(negedge clk or posedge rst) begin
    if (rst) begin
      m_rel = 0;
      m_frz = 0;
    end else begin
      if (m_rel < 2) m_rel = m_rel + 1;
      m_frz = freeze ? 1 : 0;
    end
  end

  // reference: value steps down by one modulo 8 on running rising edges
  always @(posedge clk or posedge rst) begin
    if (rst) m_val = 0;
    else if (m_rel >= 2 && m_frz == 0) m_val = (m_val + 7) % 8;
  end

  // compare against the reference on every clock (R1 R2 R3 R4 R5)
  always @(posedge clk) begin
    #2;
    if (!rst) chk("R3 model", outv(), m_val);
  end

  initial begin
    #(PERIOD * WD_CYC);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int r2c, r4c, r8c;
    int p2, p4, p8;

    // reset state R6
    #3;
    chk("R6 reset", outv(), 0);

    // R7: release while clk high
    @(posedge clk); #2 rst = 1'b0;
    @(posedge clk); #1 chk("R7 first edge", outv(), 0);
    @(posedge clk); #1 chk("R7 second edge", outv(), 7);
    chk("R3 all high", outv(), 7);

    // R1/R2 frequencies over 32 running edges
    r2c = 0; r4c = 0; r8c = 0;
    p2 = div2; p4 = div4; p8 = div8;
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1;
      if (div2 && !p2) r2c++;
      if (div4 && !p4) r4c++;
      if (div8 && !p8) r8c++;
      if (div8 && !p8) chk("R3 aligned", {div4 && !p4, div2 && !p2}, 3);
      p2 = div2; p4 = div4; p8 = div8;
    end
    chk("R1 div2 rises", r2c, 16);
    chk("R2 div4 rises", r4c, 8);
    chk("R2 div8 rises", r8c, 4);

    // R4: freeze
    @(posedge clk); #2 freeze = 1'b1;
    v = outv();
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1 chk("R4 hold", outv(), v);
    end
    // R5: resume
    @(posedge clk); #2 freeze = 1'b0;
    chk("R4 still held", outv(), v);
    @(posedge clk); #1 chk("R5 resume", outv(), (v + 7) % 8);
    @(posedge clk); #1 chk("R5 continue", outv(), (v + 6) % 8);

    // R6: asynchronous assert mid-run
    repeat (2) @(posedge clk);
    #3 rst = 1'b1;
    #1 chk("R6 async low", outv(), 0);
    @(posedge clk); #1 chk("R6 held low", outv(), 0);

    // R8: release while clk low
    @(negedge clk); #2 rst = 1'b0;
    @(posedge clk); #1 chk("R8 first edge", outv(), 0);
    @(posedge clk); #1 chk("R8 second edge", outv(), 0);
    @(posedge clk); #1 chk("R8 third edge", outv(), 7);

    // freeze applied across many edges, then resume
    @(negedge clk); #2 freeze = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk); #2 freeze = 1'b0;
    repeat (20) @(posedge clk);
    #3;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule